// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block holds two alarm registers, one for the day of the month and one for the hour. Each register is one byte wide. On every time-update strobe from an external time counter, the block compares the stored values with the current BCD date and hour. Each register carries its own ignore bit, so a field can be removed from the comparison. With the date ignored the alarm repeats every day at the chosen hour. With both fields ignored it fires on every update.

The result is a single-cycle pulse, `alarmHit`. It is produced once for each update strobe whose unmasked fields all agree with the alarm values. The alarm-flag logic that follows uses this pulse. Software writes and reads back the two registers through a small byte-wide port with a one-bit register select.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset both alarm registers read back 0x00 and `alarmHit` is low.
- R2: A write with `regWrEn` high stores `regWrData` on the clock edge. `regAddr` 0 selects the date register and `regAddr` 1 selects the hour register. `regRdData` shows the register chosen by `regAddr` from the next cycle on, and a register keeps its value when it is not written.
- R3: Bit 6 of each register ignores written data and always reads back as 0.
- R4: Bit 7 of each register is its ignore bit. A value of 1 removes that field from the comparison. A value of 0 requires bits 5..0 of the register to equal the current value of that field.
- R5: `alarmHit` is high only in the cycle right after a cycle in which `timeTick` is high and every unmasked field matches. Each such strobe gives exactly one single-cycle pulse, and `alarmHit` is low after any cycle without `timeTick`.
- R6: The comparison uses the raw 6-bit BCD code, with no binary conversion. For example, a stored hour of 0x12 does not match a current hour of 0x0C.
- R7: When both ignore bits are 1, every `timeTick` produces a pulse, including strobes in back-to-back cycles.
- R8: When a register write and `timeTick` happen in the same cycle, the comparison uses the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 1 | Register select: 0 = date, 1 = hour |
| regWrData | input | 8 | Write data: bit 7 ignore, bits 5..0 BCD value |
| regRdData | output | 8 | Read data of the selected register |
| curDate | input | 6 | Current BCD day of month |
| curHours | input | 6 | Current BCD hour |
| timeTick | input | 1 | Time-update strobe |
| alarmHit | output | 1 | Single-cycle match pulse |

## Verification
A register write becomes visible on `regRdData` one clock after the write cycle. A match pulse appears on `alarmHit` exactly one clock after the strobe cycle and lasts for that one cycle only. The bench drives every input on the falling edge and steps its reference model on the rising edge. It compares both outputs at the next falling edge, which is one edge after the rising edge where they change. Because it also compares on every cycle without a strobe, a late, early or stretched pulse is caught.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int REG_W   = 8;
  localparam int FIELD_W = 6;
  localparam int IGN_BIT = REG_W - 1;
  localparam logic [REG_W-1:0] ZERO_MASK = 8'h40;

  typedef struct packed {
    logic wrDate;
    logic wrHours;
    logic evalNow;
  } alarmStrobes_t;
endpackage

// File: rtl/bcd_alarm_ctrl.sv
module bcd_alarm_ctrl
  import bcd_alarm_pkg::*;
(
  input  logic          regWrEn,
  input  logic          regAddr,
  input  logic          timeTick,
  output alarmStrobes_t strobes
);
  always_comb begin
    strobes.wrDate  = regWrEn && !regAddr;
    strobes.wrHours = regWrEn && regAddr;
    strobes.evalNow = timeTick;
  end
endmodule

// File: rtl/bcd_alarm_dp.sv
module bcd_alarm_dp
  import bcd_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  alarmStrobes_t      strobes,
  input  logic [REG_W-1:0]   wrData,
  input  logic [FIELD_W-1:0] curDate,
  input  logic [FIELD_W-1:0] curHours,
  output logic [REG_W-1:0]   dateReg,
  output logic [REG_W-1:0]   hoursReg,
  output logic               alarmHit
);
  logic [REG_W-1:0] cleanData;
  logic dateOk, hoursOk;

  assign cleanData = wrData & ~ZERO_MASK;
  assign dateOk  = dateReg[IGN_BIT]  || (dateReg[FIELD_W-1:0]  == curDate);
  assign hoursOk = hoursReg[IGN_BIT] || (hoursReg[FIELD_W-1:0] == curHours);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dateReg  <= '0;
      hoursReg <= '0;
      alarmHit <= 1'b0;
    end else begin
      if (strobes.wrDate)  dateReg  <= cleanData;
      if (strobes.wrHours) hoursReg <= cleanData;
      alarmHit <= strobes.evalNow && dateOk && hoursOk;
    end
  end

  // R5: no pulse without a strobe in the previous cycle
  p_pulse_needs_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.evalNow |=> !alarmHit);
  // R7: both fields ignored, every strobe pulses
  p_all_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalNow && dateReg[IGN_BIT] && hoursReg[IGN_BIT]) |=> alarmHit);
  // R4: an unmasked date mismatch blocks the pulse
  p_date_mismatch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalNow && !dateReg[IGN_BIT] && dateReg[FIELD_W-1:0] != curDate) |=> !alarmHit);
  // R2: registers hold when not written
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrDate || strobes.wrHours) |=> ($stable(dateReg) && $stable(hoursReg)));
  // R3: bit 6 never set in storage
  p_zero_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dateReg[6] && !hoursReg[6]);
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [FIELD_W-1:0] curDate,
  input  logic [FIELD_W-1:0] curHours,
  input  logic               timeTick,
  output logic               alarmHit
);
  alarmStrobes_t strobes;
  logic [REG_W-1:0] dateReg, hoursReg;

  bcd_alarm_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .timeTick(timeTick),
    .strobes (strobes)
  );

  bcd_alarm_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (regWrData),
    .curDate (curDate),
    .curHours(curHours),
    .dateReg (dateReg),
    .hoursReg(hoursReg),
    .alarmHit(alarmHit)
  );

  assign regRdData = regAddr ? hoursReg : dateReg;
endmodule

// File: tb/bcd_alarm_cmp_tb.sv
module bcd_alarm_cmp_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [5:0] curDate = '0;
  logic [5:0] curHours = '0;
  logic timeTick = 1'b0;
  logic alarmHit;

  int checks = 0;
  int fails = 0;
  int mDate = 0;
  int mHours = 0;
  bit expHit = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_alarm_cmp u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .curDate(curDate),
    .curHours(curHours), .timeTick(timeTick), .alarmHit(alarmHit)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock: drive, model at rising edge, compare at next falling edge
  task automatic cyc(bit we, bit addr, int data, int date, int hr, bit tick,
                     string reqHit, string reqRd);
    regWrEn = we; regAddr = addr; regWrData = data[7:0];
    curDate = date[5:0]; curHours = hr[5:0]; timeTick = tick;
    @(posedge clk);
    expHit = tick && ((mDate & 8'h80) != 0 || (mDate & 8'h3f) == date)
                  && ((mHours & 8'h80) != 0 || (mHours & 8'h3f) == hr);
    if (we) begin
      if (addr) mHours = data & 8'hBF; else mDate = data & 8'hBF;
    end
    @(negedge clk);
    check(reqHit, alarmHit, expHit);
    check(reqRd, regRdData, addr ? mHours : mDate);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", alarmHit, 0);
    check("R1", regRdData, 0);
    regAddr = 1; #1;
    check("R1", regRdData, 0);
    rstN = 1;
    @(negedge clk);
    // R2 write/read
    cyc(1, 0, 8'h15, 0, 0, 0, "R5", "R2");
    cyc(1, 1, 8'h92, 0, 0, 0, "R5", "R2");
    cyc(0, 0, 0, 0, 0, 0, "R5", "R2");
    // R4 date compared, hours ignored
    cyc(0, 0, 0, 6'h15, 6'h07, 1, "R4", "R2");
    cyc(0, 0, 0, 6'h14, 6'h07, 1, "R4", "R2");
    cyc(0, 0, 0, 6'h15, 6'h07, 0, "R5", "R2");
    // R6 hours unmasked 0x12 vs binary twelve
    cyc(1, 1, 8'h12, 0, 0, 0, "R5", "R2");
    cyc(0, 1, 0, 6'h15, 6'h0C, 1, "R6", "R2");
    cyc(0, 1, 0, 6'h15, 6'h12, 1, "R6", "R2");
    cyc(0, 1, 0, 6'h15, 6'h12, 0, "R5", "R2");
    // R3 bit 6 ignored
    cyc(1, 0, 8'hFF, 0, 0, 0, "R5", "R3");
    cyc(0, 0, 0, 0, 0, 0, "R5", "R3");
    cyc(1, 0, 8'h40, 0, 0, 0, "R5", "R3");
    // R7 all ignored, back-to-back ticks
    cyc(1, 0, 8'h80, 0, 0, 0, "R5", "R2");
    cyc(1, 1, 8'h80, 0, 0, 0, "R5", "R2");
    cyc(0, 0, 0, 6'h01, 6'h03, 1, "R7", "R2");
    cyc(0, 0, 0, 6'h22, 6'h23, 1, "R7", "R2");
    cyc(0, 0, 0, 6'h22, 6'h23, 0, "R7", "R2");
    // R8 write with tick uses previous value
    cyc(1, 0, 8'h09, 6'h31, 0, 1, "R8", "R2");
    cyc(1, 0, 8'h80, 6'h31, 0, 1, "R8", "R2");
    cyc(0, 0, 0, 6'h31, 0, 1, "R8", "R2");
    // R4 both fields compared
    cyc(1, 0, 8'h31, 0, 0, 0, "R5", "R2");
    cyc(1, 1, 8'h23, 0, 0, 0, "R5", "R2");
    cyc(0, 1, 0, 6'h31, 6'h23, 1, "R4", "R2");
    cyc(0, 1, 0, 6'h30, 6'h23, 1, "R4", "R2");
    cyc(0, 1, 0, 6'h31, 6'h22, 1, "R4", "R2");
    cyc(0, 0, 0, 0, 0, 0, "R5", "R2");
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule